// File: doc/BRIEF.md
# LED Controller Register Target on a Two-Wire Serial Bus

This block is the host-facing register file of a three-pattern LED controller. It sits on a two-wire serial bus (I2C) as a target with the fixed 7-bit address 1010011. It gives byte access to a register space from 0x00 to 0x4F. The host writes a register pointer and then any number of data bytes. The pointer advances after each byte. To read, the host sets the pointer with a write, issues a repeated start with the read bit set, and then clocks bytes out.

Colour and timing values are written into shadow registers, and the pattern engine downstream does not see them yet. The block copies them to its active outputs only when the key byte 0xC5 arrives at one of the commit addresses. Writing the same key to the reset address puts every register back to its power-up value.

Both bus lines are open-drain. The block samples SCL and SDA on a fast system clock and pulls SDA low through `sda_oe`.

The protocol engine is a state machine with these states:
- IDLE
- DEV (device address)
- DEV_ACK
- PTR (register pointer)
- PTR_ACK
- WR (write data)
- WR_ACK
- RD (read data)
- RD_ACK (host acknowledge)

A START moves any state to DEV, and a STOP moves any state to IDLE. From DEV:
- a matching address goes to DEV_ACK;
- any other address goes back to IDLE.

From DEV_ACK the machine goes to PTR when the read bit is 0 and to RD when it is 1. The write path then runs PTR → PTR_ACK → WR → WR_ACK → WR, and the loop repeats for each byte. The read path runs RD → RD_ACK. On a host ACK it returns to RD; on a host NACK it goes to IDLE.

Top module: `led_i2c_regs`

## Requirements
- R1: The target acknowledges a device address of 1010011 followed by the read/write bit (0 write, 1 read). For any other address it leaves SDA released and ignores the bus until the next START.
- R2: In a write, the register pointer byte and then the data bytes are taken MSB first. The target acknowledges each of these bytes by pulling SDA low.
- R3: The pointer advances by one after each acknowledged data byte, so a burst fills consecutive registers.
- R4: After a pointer write, a repeated start with the read bit set returns register contents MSB first. The pointer advances after each byte that the host acknowledges, and a host NACK ends the read.
- R5: Register 0x00 always reads 0xCE, and writes to it have no effect.
- R6: Writing 0xC5 to 0x40 copies the shadow colour registers to `colour_q`. Byte k of pattern p (p and k counted from 0, k from 0 to 8) comes from register 0x10·(p+1)+k and lands at bits (9p+k)·8. `colour_q` changes at no other time, except on a register reset.
- R7: Writing 0xC5 to 0x41, 0x42 or 0x43 copies the three timing bytes of pattern 1, 2 or 3 to `timing_q` and pulses the matching bit of `pat_start` for one cycle. Timing byte k of pattern p comes from register 0x10·(p+1)+9+k and lands at bits (3p+k)·8.
- R8: The RG+W grouping is selected when bits [2:1] of register 0x01 equal 01. In this grouping, writing 0xC5 to 0x43 commits the timing of all three patterns and pulses all three `pat_start` bits.
- R9: Writing 0xC5 to 0x4F restores the power-up values, and `colour_q` and `timing_q` return to zero. The power-up values are:
  - 0x02 = 0x07;
  - 0x03 = 0x15;
  - 0x1C, 0x2C and 0x3C = 0x01;
  - 0x1E, 0x2E and 0x3E = 0x01;
  - every other register = 0x00.
- R10: A byte other than 0xC5 written to 0x40–0x43 or 0x4F does nothing. Those addresses always read 0x00.
- R11: After a STOP the target releases SDA and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| colour_q | output | N_PAT·COL_BYTES·8 | Committed colour bytes |
| timing_q | output | N_PAT·TIM_BYTES·8 | Committed pattern timing bytes |
| pat_start | output | N_PAT | One-cycle start pulse per pattern |

## Verification
The hardest case to reach is the RG+W grouping. In that grouping a single key write to 0x43 must commit all three timing groups at once. To get there through the bus, the stimulus first commits pattern 2 alone with a key write to 0x42, so pattern 2 already holds a distinct value. It then writes the grouping field in register 0x01 and sends the key to 0x43. The bench compares every timing byte and counts the start pulses on each bit. A second hard case is a read burst taken right after a pointer write. The repeated start arrives while the machine sits in WR, and the bench checks that every returned byte comes from the advancing pointer.

// File: rtl/led_i2c_pkg.sv
package led_i2c_pkg;

    parameter logic [6:0] DEV_ADDR   = 7'b1010011;
    parameter logic [7:0] COMMIT_KEY = 8'hC5;
    parameter logic [7:0] ID_VALUE   = 8'hCE;
    parameter int         REG_COUNT  = 80;
    localparam logic [7:0] REG_END   = 8'(REG_COUNT);
    parameter logic [7:0] A_MODE     = 8'h01;
    parameter logic [7:0] A_COL_UPD  = 8'h40;
    parameter logic [7:0] A_PAT_UPD  = 8'h41;
    parameter logic [7:0] A_RESET    = 8'h4F;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_PTR, S_PTR_ACK,
        S_WR, S_WR_ACK, S_RD, S_RD_ACK
    } tgt_state_e;

    function automatic logic [7:0] reg_default(input int a);
        case (a)
            'h02:                            return 8'h07;
            'h03:                            return 8'h15;
            'h1C, 'h2C, 'h3C,
            'h1E, 'h2E, 'h3E:                return 8'h01;
            default:                         return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_v,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic              scl_d, sda_d, scl_now;

    assign scl_now = scl_sr[STAGES-1];
    assign sda_v   = sda_sr[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[STAGES-2:0], sda_i};
            scl_d  <= scl_now;
            sda_d  <= sda_v;
        end
    end

    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_v;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_v;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import led_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_v,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] reg_ptr,
    output logic [7:0] wr_data,
    output logic       wr_en,
    output logic       sda_oe
);
    tgt_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg, tx;
    logic       rw, nack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            reg_ptr <= '0;
            wr_data <= '0;
            wr_en   <= 1'b0;
            rw      <= 1'b0;
            nack    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state <= S_DEV;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: begin
                    end
                    S_DEV: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_v};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state <= S_DEV_ACK;
                                rw    <= shreg[0];
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    S_DEV_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            state <= S_RD;
                            tx    <= rd_data;
                        end else begin
                            state <= S_PTR;
                        end
                    end
                    S_PTR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_v};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            state   <= S_PTR_ACK;
                            reg_ptr <= shreg;
                        end
                    end
                    S_PTR_ACK: if (scl_fall) begin
                        state <= S_WR;
                        cnt   <= '0;
                    end
                    S_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_v};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            state   <= S_WR_ACK;
                            wr_en   <= 1'b1;
                            wr_data <= shreg;
                        end
                    end
                    S_WR_ACK: if (scl_fall) begin
                        state   <= S_WR;
                        cnt     <= '0;
                        reg_ptr <= reg_ptr + 8'd1;
                    end
                    S_RD: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            state   <= S_RD_ACK;
                            reg_ptr <= reg_ptr + 8'd1;
                        end else begin
                            tx  <= {tx[6:0], 1'b0};
                            cnt <= cnt + 4'd1;
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_v;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= S_IDLE;
                            end else begin
                                state <= S_RD;
                                tx    <= rd_data;
                                cnt   <= '0;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            S_DEV_ACK, S_PTR_ACK, S_WR_ACK: sda_oe = 1'b1;
            S_RD:                           sda_oe = ~tx[7];
            default:                        sda_oe = 1'b0;
        endcase
    end

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_ACK && scl_fall && !start_det && !stop_det) |=> reg_ptr == $past(reg_ptr) + 8'd1);

endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank
    import led_i2c_pkg::*;
#(
    parameter int N_PAT     = 3,
    parameter int COL_BYTES = 9,
    parameter int TIM_BYTES = 3,
    localparam int COL_W    = N_PAT * COL_BYTES * 8,
    localparam int TIM_W    = N_PAT * TIM_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data,
    output logic [COL_W-1:0] colour_q,
    output logic [TIM_W-1:0] timing_q,
    output logic [N_PAT-1:0] pat_start
);
    logic [REG_COUNT*8-1:0] rf;
    logic [7:0] rel;
    logic       is_key, is_pat, rgw, wr_ok, do_reset, do_colour;

    assign is_key    = (wdata == COMMIT_KEY);
    assign rel       = addr - A_PAT_UPD;
    assign is_pat    = (rel < 8'(N_PAT));
    assign rgw       = (rf[int'(A_MODE)*8+1 +: 2] == 2'b01);
    assign wr_ok     = (addr != 8'h00) && (addr < REG_END) && !is_pat
                       && (addr != A_COL_UPD) && (addr != A_RESET);
    assign do_reset  = wr_en && is_key && (addr == A_RESET);
    assign do_colour = wr_en && is_key && (addr == A_COL_UPD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) rf[i*8 +: 8] <= reg_default(i);
            colour_q  <= '0;
            timing_q  <= '0;
            pat_start <= '0;
        end else begin
            pat_start <= '0;
            if (do_reset) begin
                for (int i = 0; i < REG_COUNT; i++) rf[i*8 +: 8] <= reg_default(i);
                colour_q <= '0;
                timing_q <= '0;
            end else if (do_colour) begin
                for (int p = 0; p < N_PAT; p++)
                    for (int k = 0; k < COL_BYTES; k++)
                        colour_q[(p*COL_BYTES+k)*8 +: 8] <= rf[((p+1)*16+k)*8 +: 8];
            end else if (wr_en && is_key && is_pat) begin
                for (int p = 0; p < N_PAT; p++) begin
                    if (rel == 8'(p) || (rgw && rel == 8'(N_PAT-1))) begin
                        for (int k = 0; k < TIM_BYTES; k++)
                            timing_q[(p*TIM_BYTES+k)*8 +: 8] <= rf[((p+1)*16+COL_BYTES+k)*8 +: 8];
                        pat_start[p] <= 1'b1;
                    end
                end
            end else if (wr_en && wr_ok) begin
                rf[int'(addr)*8 +: 8] <= wdata;
            end
        end
    end

    always_comb begin
        if (addr == 8'h00)       rd_data = ID_VALUE;
        else if (addr < REG_END) rd_data = rf[int'(addr)*8 +: 8];
        else                     rd_data = 8'h00;
    end

    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_start != '0) |=> (pat_start == '0));
    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_reset |=> (colour_q == '0 && timing_q == '0));
    assert_colour_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_reset && !do_colour) |=> $stable(colour_q));
    assert_nonkey_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_key) |=> (pat_start == '0));

endmodule

// File: rtl/led_i2c_regs.sv
module led_i2c_regs #(
    parameter int SYNC_STAGES = 2,
    parameter int N_PAT       = 3,
    parameter int COL_BYTES   = 9,
    parameter int TIM_BYTES   = 3,
    localparam int COL_W      = N_PAT * COL_BYTES * 8,
    localparam int TIM_W      = N_PAT * TIM_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [COL_W-1:0] colour_q,
    output logic [TIM_W-1:0] timing_q,
    output logic [N_PAT-1:0] pat_start
);
    logic       sda_v, scl_rise, scl_fall, start_det, stop_det, wr_en;
    logic [7:0] reg_ptr, wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_v(sda_v), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_v(sda_v), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .reg_ptr(reg_ptr), .wr_data(wr_data),
        .wr_en(wr_en), .sda_oe(sda_oe)
    );

    led_reg_bank #(.N_PAT(N_PAT), .COL_BYTES(COL_BYTES), .TIM_BYTES(TIM_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_ptr),
        .wdata(wr_data), .rd_data(rd_data), .colour_q(colour_q),
        .timing_q(timing_q), .pat_start(pat_start)
    );

endmodule

// File: tb/led_i2c_regs_tb.sv
module led_i2c_regs_tb;
    localparam int Q = 100;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic         sda_oe;
    logic [215:0] colour_q;
    logic [71:0]  timing_q;
    logic [2:0]   pat_start;
    wire          sda_bus = sda_m & ~sda_oe;

    int errs = 0, checks = 0;
    int starts [3] = '{default: 0};
    logic [7:0] exp_q[$], got_q[$];
    string      req_q[$];
    logic [7:0] txb [16];

    led_i2c_regs u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .colour_q(colour_q), .timing_q(timing_q),
        .pat_start(pat_start)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        for (int b = 0; b < 3; b++) if (pat_start[b]) starts[b] = starts[b] + 1;
    end

    task automatic chk(input string req, input logic [215:0] act, input logic [215:0] expv);
        checks++;
        if (act !== expv) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // scoreboard monitor: compares each byte read off the bus with the queued expectation
    initial begin
        logic [7:0] g, e;
        string r;
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    checks++; errs++;
                    $display("FAIL R4 actual=%h expected=none", g);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(r, {208'd0, g}, {208'd0, e});
                end
            end
        end
    end

    task automatic expect_b(input string r, input logic [7:0] v);
        exp_q.push_back(v);
        req_q.push_back(r);
    endtask

    task automatic put_bit(input logic b, output logic r);
        #Q sda_m = b;
        #Q scl_m = 1'b1;
        #Q r = sda_bus;
        #Q scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b1;
        #Q;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(v[i], r);
        put_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, r);
            v[i] = r;
        end
        put_bit(last, r);
    endtask

    task automatic wr_burst(input logic [7:0] a, input int n, output logic allack);
        logic k;
        bus_start();
        send_byte(8'hA6, k); allack = k;
        send_byte(a, k);     allack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(txb[i], k);
            allack &= k;
        end
        bus_stop();
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        logic k;
        txb[0] = d;
        wr_burst(a, 1, k);
        chk("R2", {215'd0, k}, {215'd0, 1'b1});
    endtask

    task automatic rd_burst(input logic [7:0] a, input int n);
        logic k1, k2, k3;
        logic [7:0] v;
        bus_start();
        send_byte(8'hA6, k1);
        send_byte(a, k2);
        bus_start();
        send_byte(8'hA7, k3);
        chk("R4", {213'd0, k1, k2, k3}, {213'd0, 3'b111});
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, v);
            got_q.push_back(v);
        end
        bus_stop();
    endtask

    initial begin
        #(200000 * 10);
        checks++; errs++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic k;
        logic [215:0] ec;
        logic [71:0]  et;
        int s0 [3];

        repeat (10) @(posedge clk);
        #2 rst_n = 1'b1;
        #Q;
        // reset state
        chk("R11", {215'd0, sda_oe}, 216'd0);
        chk("R9", colour_q, 216'd0);
        chk("R9", {144'd0, timing_q}, 216'd0);

        // R1: foreign address not acknowledged, later bytes ignored
        bus_start();
        send_byte(8'hAA, k);
        chk("R1", {215'd0, k}, 216'd0);
        send_byte(8'h02, k);
        send_byte(8'h55, k);
        bus_stop();
        expect_b("R1", 8'h07);
        rd_burst(8'h02, 1);

        // R9 power-up values via a read burst (R4)
        expect_b("R9", 8'h07); expect_b("R9", 8'h15);
        rd_burst(8'h02, 2);
        expect_b("R9", 8'h01); expect_b("R4", 8'h00); expect_b("R9", 8'h01);
        rd_burst(8'h1C, 3);

        // R5 identity register
        wr1(8'h00, 8'h12);
        expect_b("R5", 8'hCE);
        rd_burst(8'h00, 1);

        // R2/R3 burst write into pattern-1 colour shadows
        for (int i = 0; i < 9; i++) txb[i] = 8'(8'h11 + i);
        wr_burst(8'h10, 9, k);
        chk("R2", {215'd0, k}, {215'd0, 1'b1});
        for (int i = 0; i < 9; i++) expect_b("R3", 8'(8'h11 + i));
        rd_burst(8'h10, 9);
        chk("R6", colour_q, 216'd0);

        // R10 non-key write to colour commit address
        wr1(8'h40, 8'h33);
        chk("R10", colour_q, 216'd0);
        expect_b("R10", 8'h00);
        rd_burst(8'h40, 1);

        // R6 commit colours
        wr1(8'h40, 8'hC5);
        ec = '0;
        for (int i = 0; i < 9; i++) ec[i*8 +: 8] = 8'(8'h11 + i);
        chk("R6", colour_q, ec);

        // R7 timing commit of pattern 2 only
        txb[0] = 8'hA1; txb[1] = 8'hA2; txb[2] = 8'hA3; wr_burst(8'h19, 3, k);
        txb[0] = 8'hB1; txb[1] = 8'hB2; txb[2] = 8'hB3; wr_burst(8'h29, 3, k);
        txb[0] = 8'hC1; txb[1] = 8'hC2; txb[2] = 8'hC3; wr_burst(8'h39, 3, k);
        s0 = starts;
        wr1(8'h42, 8'hC5);
        et = '0;
        et[24 +: 24] = {8'hB3, 8'hB2, 8'hB1};
        chk("R7", {144'd0, timing_q}, {144'd0, et});
        chk("R7", {213'd0, 1'(starts[2]-s0[2]), 1'(starts[1]-s0[1]), 1'(starts[0]-s0[0])},
                  {213'd0, 3'b010});

        // R10 non-key write to pattern commit address
        s0 = starts;
        wr1(8'h41, 8'h00);
        chk("R10", {213'd0, 1'(starts[2]-s0[2]), 1'(starts[1]-s0[1]), 1'(starts[0]-s0[0])}, 216'd0);
        chk("R10", {144'd0, timing_q}, {144'd0, et});

        // R8 grouped commit through 0x43
        wr1(8'h01, 8'h02);
        s0 = starts;
        wr1(8'h43, 8'hC5);
        et = {8'hC3, 8'hC2, 8'hC1, 8'hB3, 8'hB2, 8'hB1, 8'hA3, 8'hA2, 8'hA1};
        chk("R8", {144'd0, timing_q}, {144'd0, et});
        chk("R8", {213'd0, 1'(starts[2]-s0[2]), 1'(starts[1]-s0[1]), 1'(starts[0]-s0[0])},
                  {213'd0, 3'b111});

        // R9 reset key
        wr1(8'h4F, 8'hC5);
        chk("R9", colour_q, 216'd0);
        chk("R9", {144'd0, timing_q}, 216'd0);
        expect_b("R9", 8'h00); expect_b("R9", 8'h07);
        rd_burst(8'h01, 2);
        expect_b("R9", 8'h00);
        rd_burst(8'h10, 1);

        chk("R11", {215'd0, sda_oe}, 216'd0);
        repeat (20) @(negedge clk);
        chk("R4", {184'd0, 32'(exp_q.size())}, 216'd0);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule